// File: doc/BRIEF.md
# Serial Video Line Coder and Serializer

This block is the digital transmit path of a serial digital video link. It takes one 10-bit video word per word period and turns it into a serial bit stream at ten times the word rate. A bit strobe paces the shifting, so the whole block runs on one fast clock. Each bit goes through a self-synchronising scrambler with generator x^9 + x^4 + 1 and then through an NRZI coder before it is registered onto the serial output.

A static bypass input switches off scrambling and NRZI coding together, so the raw word bits go out in order. The block also watches the incoming words for the three-word timing-reference preamble (all ones, all zeros, all zeros). It raises a lock flag once a preamble has been taken in and the word after it has started leaving. It drops the flag when too many words pass with no preamble.

The word source presents the next word on `word_in` and keeps it there until `word_take` pulses. The clock multiplier, the analog line driver and the termination are outside the block.

Top module: `sdv_serial_tx`

## Requirements
- R1: While reset is asserted and until the first bit strobe after it, `ser_out` is 0 and `lock` is 0. The scrambler history and the NRZI level start at zero.
- R2: `word_take` is high exactly in a cycle where `bit_en` is high and the strobe is the first of a group of ten (the first strobe after reset included). `word_in` is captured in that cycle, so consecutive takes are exactly ten strobes apart.
- R3: Each captured word is sent least significant bit first, one bit per `bit_en` strobe. `ser_out` does not change in a cycle without a strobe.
- R4: With `bypass` low, each data bit b becomes s = b XOR s(n-4) XOR s(n-9), where s(n-k) is the scrambled bit produced k strobes earlier. The history runs on across word boundaries.
- R5: With `bypass` low, the NRZI level toggles when s is 1 and holds when s is 0, and `ser_out` takes the new level.
- R6: With `bypass` high, `ser_out` takes the raw data bit at each strobe. The scrambler history and the NRZI level are frozen and resume from their held values when `bypass` falls.
- R7: When three captured words in a row are 0x3FF, 0x000, 0x000, `lock` goes high one clock after the next word capture.
- R8: `lock` goes low one clock after the capture that brings the number of captured words since the last preamble to LOSS_WORDS, unless the capture that would raise it (R7) is pending.
- R9: A strobe's bit appears on `ser_out` one clock after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit strobe, ten per word period |
| bypass | input | 1 | Static: send raw bits, no scrambling or NRZI |
| word_in | input | WORD_W | Parallel video word, held until taken |
| word_take | output | 1 | Word capture pulse |
| ser_out | output | 1 | Serial line bit |
| lock | output | 1 | Timing-reference lock flag |

## Verification
`word_take` is combinational, so it is due in the same cycle as the strobe that captures the word. The bench checks it a short delay after driving the inputs on the falling edge. The serial bit and `lock` are registered, so both are due one clock after the strobe or capture that causes them. The bench's behavioural model advances on each rising edge using the values it drove, and compares the registered outputs at the following falling edge. Strobe gaps, bypass toggles in the middle of a word and runs without a preamble all go through the same per-cycle comparison.

// File: rtl/sdv_pkg.sv
package sdv_pkg;

  // matcher position inside the three-word preamble
  typedef enum logic [1:0] {
    PRE_NONE  = 2'd0,
    PRE_ONES  = 2'd1,
    PRE_ZERO1 = 2'd2
  } pre_state_e;

  // self-synchronising scrambler: data bit mixed with two history taps
  function automatic logic mix_bit(input logic din, input logic tap_near, input logic tap_far);
    return din ^ tap_near ^ tap_far;
  endfunction

  // NRZI: a one flips the line level, a zero keeps it
  function automatic logic nrzi_step(input logic level, input logic b);
    return b ? ~level : level;
  endfunction

endpackage

// File: rtl/sdv_word_shifter.sv
module sdv_word_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [WORD_W-1:0] word_in,
  output logic              take,
  output logic              cur_bit
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  pos_q;
  logic [WORD_W-2:0] rest_q;
  logic              at_start;

  assign at_start = (pos_q == '0);
  assign take     = bit_en && at_start;
  assign cur_bit  = at_start ? word_in[0] : rest_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      rest_q <= '0;
    end else if (bit_en) begin
      if (at_start) begin
        rest_q <= word_in[WORD_W-1:1];
      end else begin
        rest_q <= {1'b0, rest_q[WORD_W-2:1]};
      end
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdv_line_coder.sv
module sdv_line_coder #(
  parameter int TAP_NEAR = 4,
  parameter int TAP_FAR  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bypass,
  input  logic cur_bit,
  output logic scr_bit,
  output logic nrz_level,
  output logic ser_out
);
  import sdv_pkg::*;

  logic [TAP_FAR-1:0] hist_q;
  logic               level_q;
  logic               line_q;
  logic               level_nx;

  assign scr_bit   = mix_bit(cur_bit, hist_q[TAP_NEAR-1], hist_q[TAP_FAR-1]);
  assign level_nx  = nrzi_step(level_q, scr_bit);
  assign nrz_level = level_q;
  assign ser_out   = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      level_q <= 1'b0;
      line_q  <= 1'b0;
    end else if (bit_en) begin
      if (bypass) begin
        line_q <= cur_bit;
      end else begin
        hist_q  <= {hist_q[TAP_FAR-2:0], scr_bit};
        level_q <= level_nx;
        line_q  <= level_nx;
      end
    end
  end
endmodule

// File: rtl/sdv_trs_watch.sv
module sdv_trs_watch #(
  parameter int WORD_W     = 10,
  parameter int LOSS_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word_in,
  output logic              trs_hit,
  output logic              lock
);
  import sdv_pkg::*;

  localparam int SIL_W = $clog2(LOSS_WORDS + 1);

  pre_state_e       st_q;
  logic [SIL_W-1:0] quiet_q;
  logic             pend_q;
  logic             lock_q;
  logic             is_ones;
  logic             is_zero;

  assign is_ones = &word_in;
  assign is_zero = ~|word_in;
  assign trs_hit = take && (st_q == PRE_ZERO1) && is_zero;
  assign lock    = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PRE_NONE;
    end else if (take) begin
      case (st_q)
        PRE_NONE:  st_q <= is_ones ? PRE_ONES : PRE_NONE;
        PRE_ONES:  st_q <= is_zero ? PRE_ZERO1 : (is_ones ? PRE_ONES : PRE_NONE);
        PRE_ZERO1: st_q <= is_ones ? PRE_ONES : PRE_NONE;
        default:   st_q <= PRE_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
      pend_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else if (take) begin
      if (trs_hit) begin
        pend_q  <= 1'b1;
        quiet_q <= '0;
      end else begin
        if (int'(quiet_q) != LOSS_WORDS) begin
          quiet_q <= quiet_q + 1'b1;
        end
        if (pend_q) begin
          lock_q <= 1'b1;
          pend_q <= 1'b0;
        end else if (int'(quiet_q) + 1 >= LOSS_WORDS) begin
          lock_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sdv_serial_tx.sv
module sdv_serial_tx #(
  parameter int WORD_W     = 10,
  parameter int LOSS_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bypass,
  input  logic [WORD_W-1:0] word_in,
  output logic              word_take,
  output logic              ser_out,
  output logic              lock
);
  logic cur_bit;
  logic scr_bit;
  logic nrz_level;
  logic trs_hit;

  sdv_word_shifter #(.WORD_W(WORD_W)) shift_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .word_in (word_in),
    .take    (word_take),
    .cur_bit (cur_bit)
  );

  sdv_line_coder #(.TAP_NEAR(4), .TAP_FAR(9)) coder_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bypass    (bypass),
    .cur_bit   (cur_bit),
    .scr_bit   (scr_bit),
    .nrz_level (nrz_level),
    .ser_out   (ser_out)
  );

  sdv_trs_watch #(.WORD_W(WORD_W), .LOSS_WORDS(LOSS_WORDS)) watch_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (word_take),
    .word_in (word_in),
    .trs_hit (trs_hit),
    .lock    (lock)
  );
endmodule

// File: rtl/sdv_serial_tx_chk.sv
module sdv_serial_tx_chk #(
  parameter int WORD_W = 10
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic bypass,
  input logic word_take,
  input logic ser_out,
  input logic lock,
  input logic cur_bit,
  input logic scr_bit,
  input logic nrz_level,
  input logic trs_hit
);
  int   gap_q;
  logic seen_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (bit_en) begin
        if (word_take) begin
          gap_q  <= 1;
          seen_q <= 1'b1;
        end else begin
          gap_q <= gap_q + 1;
        end
      end
      if (word_take && trs_hit) pend_q <= 1'b1;
      else if (word_take) pend_q <= 1'b0;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (!lock && !ser_out));

  p_take_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> bit_en);

  p_word_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> (!seen_q || gap_q == WORD_W));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));

  p_nrzi_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !bypass) |=> (ser_out == ($past(nrz_level) ^ $past(scr_bit))));

  p_bypass_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bypass) |=> (ser_out == $past(cur_bit)));

  p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> ($past(word_take) && pend_q == 1'b0));

  p_lock_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_take && pend_q && !trs_hit) |=> lock);
endmodule

bind sdv_serial_tx sdv_serial_tx_chk #(.WORD_W(WORD_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .bypass    (bypass),
  .word_take (word_take),
  .ser_out   (ser_out),
  .lock      (lock),
  .cur_bit   (cur_bit),
  .scr_bit   (scr_bit),
  .nrz_level (nrz_level),
  .trs_hit   (trs_hit)
);

// File: tb/sdv_serial_tx_tb.sv
`timescale 1ns/1ps
module sdv_serial_tx_tb_top;
  localparam int W    = 10;
  localparam int LOSS = 8;
  localparam int ALL1 = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         byp = 1'b0;
  logic [W-1:0] wd = '0;
  logic         take;
  logic         sout;
  logic         lk;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference state
  int bitq[$];
  int hist[$];
  int winq[$];
  int lvl = 0;
  int exp_out = 0;
  int exp_lock = 0;
  int pend = 0;
  int quiet = 0;
  int widx = 0;

  always #2 clk = ~clk;

  sdv_serial_tx #(.WORD_W(W), .LOSS_WORDS(LOSS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(en), .bypass(byp),
    .word_in(wd), .word_take(take), .ser_out(sout), .lock(lk)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick_word(input int idx, input int phase);
    int m;
    if (phase == 3) return 1 + ($urandom % (ALL1 - 1));
    m = idx % 6;
    if (m == 0) return ALL1;
    if (m == 1 || m == 2) return 0;
    return $urandom % (ALL1 + 1);
  endfunction

  task automatic model_step();
    int b;
    int s;
    bit hit;
    if (!en) return;
    if (bitq.size() == 0) begin
      for (int i = 0; i < W; i++) bitq.push_back((wd >> i) & 1);
      winq.push_back(int'(wd));
      if (winq.size() > 3) void'(winq.pop_front());
      hit = (winq.size() == 3) && winq[0] == ALL1 && winq[1] == 0 && winq[2] == 0;
      if (hit) begin
        pend = 1; quiet = 0;
      end else begin
        if (quiet < LOSS) quiet++;
        if (pend) begin exp_lock = 1; pend = 0; end
        else if (quiet >= LOSS) exp_lock = 0;
      end
      widx++;
    end
    b = bitq.pop_front();
    if (byp) begin
      exp_out = b;
    end else begin
      s = b ^ hist[hist.size()-4] ^ hist[hist.size()-9];
      hist.push_back(s);
      void'(hist.pop_front());
      lvl ^= s;
      exp_out = lvl;
    end
  endtask

  task automatic run_phase(input int cycles, input int phase);
    string rq;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      rq = byp ? "R6 R3 R9" : "R4 R5 R3 R9";
      check(rq, int'(sout), exp_out);
      check("R7 R8", int'(lk), exp_lock);
      en = (phase == 3) ? 1'b1 : (($urandom % 7) != 0);
      if (phase == 2) byp = 1'b1;
      else if (phase == 4) byp = (($urandom % 13) == 0) ? ~byp : byp;
      else byp = 1'b0;
      wd = W'(pick_word(widx, phase));
      #0.5;
      check("R2", int'(take), int'(en && bitq.size() == 0));
      @(posedge clk);
      model_step();
    end
  endtask

  initial begin
    for (int i = 0; i < 9; i++) hist.push_back(0);
    repeat (3) @(negedge clk);
    check("R1", int'(sout), 0);
    check("R1", int'(lk), 0);
    check("R1", int'(take), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(sout), 0);
    check("R1", int'(lk), 0);
    run_phase(1500, 1);
    check("R7", int'(lk), 1);
    run_phase(800, 2);
    check("R7", int'(lk), 1);
    run_phase(1500, 3);
    check("R8", int'(lk), 0);
    run_phase(2000, 4);
    run_phase(600, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule